// File: doc/BRIEF.md
# Masked Packed Integer-to-Double Converter

This unit is a vector datapath stage that turns packed signed 32-bit integers into packed IEEE-754 double-precision values. Each 64-bit destination lane takes one 32-bit source element. A vector-length select sets how many lanes are active: two, four or eight. A per-lane write mask decides which lanes take the converted value. A masked-off lane either keeps its old destination content or is cleared, as the merge-or-zero flag selects. A broadcast flag makes every lane convert the lowest source element instead of its own.

Two instruction forms are supported. In the legacy form only the two lowest lanes are converted, the mask and broadcast flags are ignored, and destination bits above 127 pass through from the old value. In the extended form every destination bit above the selected vector length is forced to zero. A 4-bit register-specifier field must read all ones. Any other value raises an undefined-opcode fault, and the old destination is returned unchanged. A rounding-mode request input exists but has no effect, because every 32-bit integer is exact in double precision. The result and its flags are registered and appear one cycle after the request.

Top module: `pk_i2d_conv`

## Requirements
- R1: `vlen_sel` encoding 2'b00 gives 2 active lanes (128 bits), 2'b01 gives 4 lanes (256 bits), and 2'b10 or 2'b11 gives 8 lanes (512 bits). Lane j reads `src_vec[32j+31:32j]` and writes `dst_out[64j+63:64j]`.
- R2: An active written lane holds the exact double value of its signed source element: bit 63 is the sign, the exponent field is 1023 plus the position of the leading one of the magnitude, and the fraction holds the bits below the leading one, left-aligned and padded with zeros.
- R3: Source 0 gives 64'h0000000000000000, and source 32'h80000000 gives 64'hC1E0000000000000.
- R4: In the extended form, an active lane is written with its converted value when `mask_en` is 0 or when its bit in `lane_mask` is 1.
- R5: In the extended form, an active lane whose mask bit is 0 while `mask_en` is 1 keeps its `old_dst` lane when `zero_mode` is 0, and becomes all zeros when `zero_mode` is 1.
- R6: When `bcast_en` is 1 in the extended form, every active lane converts `src_vec[31:0]`.
- R7: In the extended form (`legacy_form` = 0), all destination bits at and above the selected vector length are zero.
- R8: When `legacy_form` is 1, lanes 0 and 1 are converted from their own elements regardless of `lane_mask`, `mask_en`, `bcast_en` and `vlen_sel`, and `dst_out[511:128]` equals `old_dst[511:128]`.
- R9: `round_req` has no effect on any output.
- R10: When `spec_field` is not 4'b1111, `out_fault` is 1 with `out_valid`, and `dst_out` equals `old_dst`. Otherwise `out_fault` is 0.
- R11: `out_valid` is 1 for exactly the one cycle after each cycle with `in_valid` = 1. `dst_out` holds its value while no request arrives.
- R12: After reset, `out_valid` and `out_fault` are 0 and `dst_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one cycle per conversion |
| src_vec | input | 256 | Packed signed 32-bit source elements |
| lane_mask | input | 8 | Per-lane write mask |
| old_dst | input | 512 | Previous destination value |
| vlen_sel | input | 2 | Vector length: 00=128, 01=256, 1x=512 |
| mask_en | input | 1 | Apply lane_mask when 1 |
| zero_mode | input | 1 | Clear masked-off lanes when 1, keep when 0 |
| bcast_en | input | 1 | All lanes use the lowest source element |
| legacy_form | input | 1 | Legacy two-lane form with upper bits preserved |
| round_req | input | 1 | Rounding request, ignored |
| spec_field | input | 4 | Register-specifier field, must be 4'b1111 |
| out_valid | output | 1 | Result valid, one cycle |
| out_fault | output | 1 | Undefined-opcode fault for this result |
| dst_out | output | 512 | Registered destination value |

## Verification
The assertions assume that `in_valid` is driven to a known level in every cycle after reset. They also assume that the data and mode inputs are stable and defined in each cycle where `in_valid` is 1, because the properties sample them with `$past` one cycle later. The bench changes inputs only on the falling clock edge. It raises `in_valid` for single cycles with the whole request set up at once, and leaves every input defined from the start, even the unused upper source bits. One table entry uses the spare `vlen_sel` code 2'b11 to confirm that it maps to the full length.

// File: rtl/pk_i2d_pkg.sv
package pk_i2d_pkg;
  localparam int INT_W   = 32;
  localparam int FP_W    = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int LANES   = 8;
  localparam int SPEC_W  = 4;
  localparam logic [SPEC_W-1:0] SPEC_OK = '1;
  localparam int LEGACY_LANES = 2;

  typedef enum logic [1:0] {
    VL_128 = 2'b00,
    VL_256 = 2'b01,
    VL_512 = 2'b10,
    VL_ALT = 2'b11
  } vlen_e;

  function automatic int lanes_for(input logic [1:0] vl);
    case (vl)
      VL_128:  return 2;
      VL_256:  return 4;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/i2d_lane_cvt.sv
module i2d_lane_cvt #(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [INT_W-1:0]          int_in,
  output logic [EXP_W+FRAC_W:0]     fp_out
);
  localparam int BIAS  = (1 << (EXP_W-1)) - 1;
  localparam int CNT_W = $clog2(INT_W) + 1;
  localparam int PAD_W = FRAC_W - (INT_W - 1);

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [CNT_W-1:0] lzc;
  logic             found;
  logic [INT_W-1:0] aligned;
  logic [EXP_W-1:0] exp_f;

  always_comb begin
    neg = int_in[INT_W-1];
    mag = neg ? (~int_in + 1'b1) : int_in;
  end

  always_comb begin
    lzc   = CNT_W'(INT_W);
    found = 1'b0;
    for (int i = INT_W-1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lzc   = CNT_W'(INT_W-1-i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    aligned = mag << lzc;
    exp_f   = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lzc);
    if (!found) begin
      fp_out = '0;
    end else begin
      fp_out = {neg, exp_f, aligned[INT_W-2:0], {PAD_W{1'b0}}};
    end
  end

  // R2: sign of a nonzero result follows the source sign
  always_comb begin
    if (!$isunknown(int_in) && (int_in != '0)) begin
      a_r2_sign_match: assert (fp_out[EXP_W+FRAC_W] == int_in[INT_W-1]);
    end
  end
endmodule

// File: rtl/i2d_lane_write.sv
module i2d_lane_write #(
  parameter int FP_W = 64
) (
  input  logic [FP_W-1:0] cvt_val,
  input  logic [FP_W-1:0] old_val,
  input  logic            lane_active,
  input  logic            lane_wr,
  input  logic            zero_mode,
  input  logic            keep_upper,
  output logic [FP_W-1:0] new_val
);
  always_comb begin
    if (!lane_active) begin
      new_val = keep_upper ? old_val : '0;
    end else if (lane_wr) begin
      new_val = cvt_val;
    end else begin
      new_val = zero_mode ? '0 : old_val;
    end
  end
endmodule

// File: rtl/pk_i2d_conv.sv
module pk_i2d_conv
  import pk_i2d_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int EL_W    = INT_W,
  parameter int RES_W   = FP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_LANES*EL_W-1:0] src_vec,
  input  logic [N_LANES-1:0]      lane_mask,
  input  logic [N_LANES*RES_W-1:0] old_dst,
  input  logic [1:0]              vlen_sel,
  input  logic                    mask_en,
  input  logic                    zero_mode,
  input  logic                    bcast_en,
  input  logic                    legacy_form,
  input  logic                    round_req,
  input  logic [SPEC_W-1:0]       spec_field,
  output logic                    out_valid,
  output logic                    out_fault,
  output logic [N_LANES*RES_W-1:0] dst_out
);
  localparam int DST_W = N_LANES*RES_W;
  localparam int LEG_W = LEGACY_LANES*RES_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic             bad_spec;
  logic             rnd_unused;
  int               act_lanes;
  logic [DST_W-1:0] lanes_next;
  logic [DST_W-1:0] dst_next;
  logic             valid_next;
  logic             fault_next;

  always_comb begin
    bad_spec   = (spec_field != SPEC_OK);
    rnd_unused = round_req;
    act_lanes  = legacy_form ? LEGACY_LANES : lanes_for(vlen_sel);
  end

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic [EL_W-1:0]  elem;
    logic [RES_W-1:0] cvt;
    logic             active, wr;

    always_comb begin
      elem   = (bcast_en && !legacy_form) ? src_vec[EL_W-1:0]
                                          : src_vec[j*EL_W +: EL_W];
      active = (j < act_lanes);
      wr     = legacy_form || !mask_en || lane_mask[j];
    end

    i2d_lane_cvt #(.INT_W(EL_W), .EXP_W(EXP_W), .FRAC_W(RES_W-EXP_W-1)) i_cvt (
      .int_in (elem),
      .fp_out (cvt)
    );

    i2d_lane_write #(.FP_W(RES_W)) i_wr (
      .cvt_val     (cvt),
      .old_val     (old_dst[j*RES_W +: RES_W]),
      .lane_active (active),
      .lane_wr     (wr),
      .zero_mode   (zero_mode),
      .keep_upper  (legacy_form),
      .new_val     (lanes_next[j*RES_W +: RES_W])
    );
  end

  always_comb begin
    valid_next = in_valid;
    fault_next = in_valid && bad_spec;
    if (in_valid) begin
      dst_next = bad_spec ? old_dst : lanes_next;
    end else begin
      dst_next = dst_out;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      dst_out   <= '0;
    end else begin
      out_valid <= valid_next;
      out_fault <= fault_next;
      if (in_valid) begin
        dst_out <= dst_next;
      end
    end
  end

  // R11: one result per request, one cycle later
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> $stable(dst_out));
  // R10: fault leaves destination untouched and only comes with valid
  a_r10_fault_keeps: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && spec_field != SPEC_OK) |=> (out_fault && dst_out == $past(old_dst)));
  a_r10_fault_with_valid: assert property (@(posedge clk) disable iff (!rst_q)
    out_fault |-> out_valid);
  // R8: legacy form passes the upper bits through
  a_r8_legacy_upper: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && spec_field == SPEC_OK && legacy_form)
      |=> dst_out[DST_W-1:LEG_W] == $past(old_dst[DST_W-1:LEG_W]));
  // R7: extended form at 128 bits clears everything above
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && spec_field == SPEC_OK && !legacy_form && vlen_sel == VL_128)
      |=> dst_out[DST_W-1:LEG_W] == '0);
endmodule

// File: tb/test_pk_i2d_conv.sv
module test_pk_i2d_conv;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] src_vec = '0;
  logic [7:0]   lane_mask = '0;
  logic [511:0] old_dst = '0;
  logic [1:0]   vlen_sel = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, bcast_en = 1'b0;
  logic         legacy_form = 1'b0, round_req = 1'b0;
  logic [3:0]   spec_field = 4'hF;
  logic         out_valid, out_fault;
  logic [511:0] dst_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pk_i2d_conv i_pk_i2d_conv (
    .clk, .rst_n, .in_valid, .src_vec, .lane_mask, .old_dst, .vlen_sel,
    .mask_en, .zero_mode, .bcast_en, .legacy_form, .round_req, .spec_field,
    .out_valid, .out_fault, .dst_out
  );

  typedef struct packed {
    logic [255:0] src;
    logic [7:0]   mask;
    logic [1:0]   vl;
    logic         men, zm, bc, leg, rnd;
    logic [3:0]   spec;
  } vec_t;

  localparam logic [255:0] S0 = {32'd12345, 32'hFFFFFFF9, 32'd100, 32'h7FFFFFFF,
                                 32'h80000000, 32'd1, 32'hFFFFFFFF, 32'd0};
  localparam logic [255:0] S1 = {32'h00010000, 32'hDEADBEEF, 32'h00000003, 32'hFFFF0000,
                                 32'h12345678, 32'h80000001, 32'h40000000, 32'hC0000000};

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{S0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF}, // R1 R2 full length
    '{S1, 8'hA5, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF}, // R4 R5 merge
    '{S1, 8'h3C, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF}, // R5 zero
    '{S0, 8'h96, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'hF}, // R1 R7 256
    '{S1, 8'h00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF}, // R6 R7 128
    '{S1, 8'h55, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'hF}, // R6 R5
    '{S0, 8'h00, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF}, // R8 legacy
    '{S1, 8'hFF, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h7}, // R10 fault
    '{S1, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF}, // R1 R9 alt code
    '{S0, 8'hF0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'hE}  // R10 legacy fault
  };

  function automatic logic [63:0] ref_cvt(input logic [31:0] x);
    return $realtobits($itor($signed(x)));
  endfunction

  function automatic logic [511:0] ref_dst(input vec_t v, input logic [511:0] od);
    logic [511:0] r = od;
    int n;
    if (v.spec != 4'hF) return od;
    n = v.leg ? 2 : (v.vl == 2'b00 ? 2 : (v.vl == 2'b01 ? 4 : 8));
    for (int j = 0; j < 8; j++) begin
      logic [31:0] e = (v.bc && !v.leg) ? v.src[31:0] : v.src[j*32 +: 32];
      if (j >= n) begin
        if (!v.leg) r[j*64 +: 64] = '0;
      end else if (v.leg || !v.men || v.mask[j]) begin
        r[j*64 +: 64] = ref_cvt(e);
      end else if (v.zm) begin
        r[j*64 +: 64] = '0;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic [511:0] od);
    @(negedge clk);
    src_vec = v.src; lane_mask = v.mask; vlen_sel = v.vl; mask_en = v.men;
    zero_mode = v.zm; bcast_en = v.bc; legacy_form = v.leg; round_req = v.rnd;
    spec_field = v.spec; old_dst = od; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [511:0] od, prev;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", {511'd0, out_valid}, '0);
    chk("R12 fault", {511'd0, out_fault}, '0);
    chk("R12 dst", dst_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      od = {16{32'hA5A50000 | 32'(i)}};
      apply(TBL[i], od);
      chk("R11 valid", {511'd0, out_valid}, 512'd1);
      chk("R10 fault flag", {511'd0, out_fault}, {511'd0, TBL[i].spec != 4'hF});
      chk("R1-table dst", dst_out, ref_dst(TBL[i], od));
      if (i == 0) begin
        chk("R3 zero", {448'd0, dst_out[63:0]}, {448'd0, 64'h0000000000000000});
        chk("R2 minus one", {448'd0, dst_out[127:64]}, {448'd0, 64'hBFF0000000000000});
        chk("R2 one", {448'd0, dst_out[191:128]}, {448'd0, 64'h3FF0000000000000});
        chk("R3 min int", {448'd0, dst_out[255:192]}, {448'd0, 64'hC1E0000000000000});
        chk("R2 max int", {448'd0, dst_out[319:256]}, {448'd0, 64'h41DFFFFFFFC00000});
      end
      if (i == 6) chk("R8 upper kept", {128'd0, dst_out[511:128]}, {128'd0, od[511:128]});
      if (i == 4) chk("R7 upper zero", {128'd0, dst_out[511:128]}, '0);
      @(negedge clk);
      chk("R11 single pulse", {511'd0, out_valid}, '0);
    end

    // R9: same request with and without rounding request
    apply(TBL[1], '1);
    prev = dst_out;
    begin
      vec_t v = TBL[1];
      v.rnd = 1'b1;
      apply(v, '1);
    end
    chk("R9 rounding ignored", dst_out, prev);

    // R11: destination holds with no request while inputs change
    prev = dst_out;
    @(negedge clk);
    src_vec = ~src_vec; old_dst = '0; spec_field = 4'h0;
    repeat (3) @(negedge clk);
    chk("R11 hold", dst_out, prev);
    chk("R10 no fault idle", {511'd0, out_fault}, '0);
    spec_field = 4'hF;

    // R12: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 reset again", dst_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule